// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a memory-mapped SPI master. Software programs a 32-bit mode word that selects clock polarity, clock phase, bit order, word length, an internal loopback path and an aligned data layout. Writing a word to the transmit register shifts it out on the serial data output while a word is gathered from the serial input. The received word is latched into the receive register, and event flags record both the completed word and the moment the transmit holding register frees up.

Each event flag stays set until software writes a 1 to its bit position. A mask word selects which flags drive the single interrupt output. The serial clock rate is set by an external divider. That divider reads the divide-by-16 and prescale fields through a dedicated output and returns one pulse per half period of the serial clock. Chip selects are generated outside the block.

Top module: `spi_regmaster`

## Requirements
- R1: After reset, all six registers read 0 (mode 0x20, event 0x24, mask 0x28, command 0x2C, transmit 0x30, receive 0x34). The serial clock, the data output and the interrupt are all low.
- R2: The mode register keeps bits 30:16 and bit 14 and reads 0 in every other bit. div_cfg_o carries mode bit 27 above mode bits 19:16. The command register reads back the last value written and has no effect on shifting.
- R3: The length code in mode bits 23:20 gives a word of code+1 bits for codes 3 to 15 and 32 bits for code 0. A word produces exactly two serial clock transitions per bit. Transmit bits above the word length are ignored.
- R4: When mode bit 26 is 1, the most significant bit of the word is sent first. When it is 0, bit 0 is sent first. Received bits are assembled in the same order.
- R5: While no word is in flight, the serial clock rests at the level given by mode bit 29. With mode bit 28 at 0, data is sampled on the first clock transition of each bit. With bit 28 at 1, data is sampled on the second transition.
- R6: With mode bit 30 set, the receiver takes the block's own serial output and ignores miso_i. With bit 30 clear, it samples miso_i.
- R7: A transmit write starts a word only when mode bits 24 (enable) and 25 (master) are both 1. Any other transmit write is dropped: no clock transition, no event, and no later start.
- R8: When the shifter takes a word, event bit 8 (transmit not full) is set. At the end of the word, the received word is latched and event bit 9 (receive not empty) is set.
- R9: Writing 1 to an event bit clears it. Bits written with 0 keep their value. A set on the same cycle wins over the clear.
- R10: irq_o is high exactly when some event bit is set whose mask bit, at the same position (9 or 8), is also set.
- R11: Mode bit 14 selects the aligned layout. In that layout with MSB-first order, transmit words of up to 8 bits are taken from bits 31:24 and words of 9 to 16 bits from bits 31:16, and the received word is placed from bit 16 upward. With LSB-first order, transmit data is taken from bit 0, and received words of up to 8 bits start at bit 8 while longer ones start at bit 0.
- R12: Clearing the enable bit aborts a word in flight. The clock goes back to its idle level, no receive event is raised, and the next word starts again from its first bit.
- R13: Mode changes written during a word do not alter that word's length, order or layout. They apply from the next word on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr, no read side effects |
| half_tick | input | 1 | One-cycle pulse per serial clock half period, from the external divider |
| div_cfg_o | output | 5 | Divide-by-16 flag and prescale modulus for the external divider |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | Masked event interrupt |

## Verification
Words are sent in all four polarity and phase combinations, at lengths of 4, 8, 12, 13, 16 and 32 bits, in both bit orders. A bench monitor records the output bit at each sampling edge, so a swapped bit order, a wrong sampling edge or a wrong bit count shows up as a mismatched bit sequence or transition count. Loopback words are compared against a constant serial input, which separates the internal return path from the pin. Aligned-layout words test each shift rule apart from the others. Transfers that are dropped, aborted or reconfigured mid-word check that the state left behind matches the rules rather than a word that was cut off or mixed up.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;

  localparam int DATA_W = 32;
  localparam int CNT_W  = 6;

  // register byte offsets (software map)
  localparam int OFS_MODE  = 'h20;
  localparam int OFS_EVENT = 'h24;
  localparam int OFS_MASK  = 'h28;
  localparam int OFS_CMD   = 'h2C;
  localparam int OFS_TX    = 'h30;
  localparam int OFS_RX    = 'h34;

  // mode bit positions
  localparam int MB_LOOP   = 30;
  localparam int MB_CPOL   = 29;
  localparam int MB_CPHA   = 28;
  localparam int MB_DIV16  = 27;
  localparam int MB_MSB    = 26;
  localparam int MB_MASTER = 25;
  localparam int MB_EN     = 24;
  localparam int MB_LEN_LO = 20;
  localparam int MB_PM_LO  = 16;
  localparam int MB_ALIGN  = 14;

  localparam logic [DATA_W-1:0] MODE_KEEP = 32'h7FFF_4000;

  // event bit positions
  localparam int EV_NE_BIT = 9;
  localparam int EV_NF_BIT = 8;

  typedef struct packed {
    logic [CNT_W-1:0] nbits;
    logic             msb;
    logic             cpha;
    logic             cpol;
    logic             loop;
    logic             align;
  } xfer_cfg_t;

  function automatic logic [CNT_W-1:0] code_to_bits(input logic [3:0] code);
    if (code == 4'd0) return 6'd32;
    return {2'b00, code} + 6'd1;
  endfunction

  function automatic logic [DATA_W-1:0] word_mask(input logic [CNT_W-1:0] nbits);
    if (nbits >= 6'd32) return '1;
    return (32'd1 << nbits) - 32'd1;
  endfunction

  function automatic logic [4:0] tx_align_shift(input xfer_cfg_t c);
    if (!c.align || !c.msb) return 5'd0;
    if (c.nbits <= 6'd8)    return 5'd24;
    if (c.nbits <= 6'd16)   return 5'd16;
    return 5'd0;
  endfunction

  function automatic logic [4:0] rx_align_shift(input xfer_cfg_t c);
    if (!c.align) return 5'd0;
    if (c.msb)    return (c.nbits <= 6'd16) ? 5'd16 : 5'd0;
    return (c.nbits <= 6'd8) ? 5'd8 : 5'd0;
  endfunction

  // position inside the word of the bit handled at step cnt
  function automatic logic [4:0] bit_index(input logic [CNT_W-1:0] cnt,
                                           input logic [CNT_W-1:0] nbits,
                                           input logic msb);
    logic [CNT_W-1:0] t;
    t = msb ? (nbits - 6'd1 - cnt) : cnt;
    return t[4:0];
  endfunction

endpackage

// File: rtl/spi_rm_regs.sv
module spi_rm_regs
  import spi_rm_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_word,
  output logic              mode_en,
  output logic              idle_cpol,
  output logic [4:0]        div_cfg,
  output logic              load,
  output xfer_cfg_t         load_cfg,
  output logic [DATA_W-1:0] load_word,
  output logic              ne_set,
  output logic              nf_set,
  output logic [1:0]        ev_bits,
  output logic [1:0]        mask_bits,
  output logic              irq
);

  logic [DATA_W-1:0] mode_q, cmd_q, tx_hold_q, rx_q;
  logic              tx_full_q;
  logic [1:0]        ev_q, mask_q;
  logic              wr_mode, wr_event, wr_mask, wr_cmd, wr_tx;
  logic              mode_master;
  logic [1:0]        ev_clr, ev_set;

  assign wr_mode  = bus_wr && (bus_addr == ADDR_W'(OFS_MODE));
  assign wr_event = bus_wr && (bus_addr == ADDR_W'(OFS_EVENT));
  assign wr_mask  = bus_wr && (bus_addr == ADDR_W'(OFS_MASK));
  assign wr_cmd   = bus_wr && (bus_addr == ADDR_W'(OFS_CMD));
  assign wr_tx    = bus_wr && (bus_addr == ADDR_W'(OFS_TX));

  assign mode_en     = mode_q[MB_EN];
  assign mode_master = mode_q[MB_MASTER];
  assign idle_cpol   = mode_q[MB_CPOL];
  assign div_cfg     = {mode_q[MB_DIV16], mode_q[MB_PM_LO+3:MB_PM_LO]};

  always_comb begin
    load_cfg.nbits = code_to_bits(mode_q[MB_LEN_LO+3:MB_LEN_LO]);
    load_cfg.msb   = mode_q[MB_MSB];
    load_cfg.cpha  = mode_q[MB_CPHA];
    load_cfg.cpol  = mode_q[MB_CPOL];
    load_cfg.loop  = mode_q[MB_LOOP];
    load_cfg.align = mode_q[MB_ALIGN];
  end

  assign load      = mode_en && mode_master && tx_full_q && !busy;
  assign load_word = (tx_hold_q >> tx_align_shift(load_cfg)) & word_mask(load_cfg.nbits);

  assign ne_set = done;
  assign nf_set = load;
  assign ev_set = {ne_set, nf_set};
  assign ev_clr = wr_event ? {bus_wdata[EV_NE_BIT], bus_wdata[EV_NF_BIT]} : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      cmd_q     <= '0;
      mask_q    <= '0;
      ev_q      <= '0;
      tx_hold_q <= '0;
      tx_full_q <= 1'b0;
      rx_q      <= '0;
    end else begin
      if (wr_mode) mode_q <= bus_wdata & MODE_KEEP;
      if (wr_cmd)  cmd_q  <= bus_wdata;
      if (wr_mask) mask_q <= {bus_wdata[EV_NE_BIT], bus_wdata[EV_NF_BIT]};
      ev_q <= (ev_q & ~ev_clr) | ev_set;
      if (!mode_en) begin
        tx_full_q <= 1'b0;
      end else if (load) begin
        tx_full_q <= 1'b0;
      end else if (wr_tx && mode_master && !tx_full_q) begin
        tx_hold_q <= bus_wdata;
        tx_full_q <= 1'b1;
      end
      if (done) rx_q <= rx_word;
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFS_MODE):  bus_rdata = mode_q;
      ADDR_W'(OFS_EVENT): bus_rdata = {22'd0, ev_q, 8'd0};
      ADDR_W'(OFS_MASK):  bus_rdata = {22'd0, mask_q, 8'd0};
      ADDR_W'(OFS_CMD):   bus_rdata = cmd_q;
      ADDR_W'(OFS_TX):    bus_rdata = tx_hold_q;
      ADDR_W'(OFS_RX):    bus_rdata = rx_q;
      default:            bus_rdata = '0;
    endcase
  end

  assign ev_bits   = ev_q;
  assign mask_bits = mask_q;
  assign irq       = |(ev_q & mask_q);

endmodule

// File: rtl/spi_rm_shift.sv
module spi_rm_shift
  import spi_rm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              idle_cpol,
  input  logic              load,
  input  xfer_cfg_t         load_cfg,
  input  logic [DATA_W-1:0] load_word,
  input  logic              half_tick,
  input  logic              miso_i,
  output logic              busy,
  output logic              done,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_word
);

  xfer_cfg_t         cfg_q;
  logic [DATA_W-1:0] tx_q, rx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, half_q, sck_q, mosi_q, done_q;
  logic              in_bit, last_bit, lead_ev, trail_ev;
  logic [4:0]        pos, pos_next;

  assign in_bit   = cfg_q.loop ? mosi_q : miso_i;
  assign pos      = bit_index(cnt_q, cfg_q.nbits, cfg_q.msb);
  assign pos_next = bit_index(cnt_q + 6'd1, cfg_q.nbits, cfg_q.msb);
  assign last_bit = (cnt_q == cfg_q.nbits - 6'd1);
  assign lead_ev  = busy_q && half_tick && !half_q;
  assign trail_ev = busy_q && half_tick && half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      half_q <= 1'b0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
    end else if (!en) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      half_q <= 1'b0;
      done_q <= 1'b0;
      sck_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load && !busy_q) begin
        busy_q <= 1'b1;
        cfg_q  <= load_cfg;
        tx_q   <= load_word;
        rx_q   <= '0;
        cnt_q  <= '0;
        half_q <= 1'b0;
        sck_q  <= load_cfg.cpol;
        mosi_q <= load_word[bit_index(6'd0, load_cfg.nbits, load_cfg.msb)];
      end else if (lead_ev) begin
        sck_q  <= ~sck_q;
        half_q <= 1'b1;
        if (!cfg_q.cpha) rx_q[pos] <= in_bit;
        else             mosi_q    <= tx_q[pos];
      end else if (trail_ev) begin
        sck_q  <= ~sck_q;
        half_q <= 1'b0;
        if (cfg_q.cpha) rx_q[pos] <= in_bit;
        if (last_bit) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 6'd1;
          if (!cfg_q.cpha) mosi_q <= tx_q[pos_next];
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign sck_o   = busy_q ? sck_q : idle_cpol;
  assign mosi_o  = mosi_q;
  assign rx_word = (rx_q & word_mask(cfg_q.nbits)) << rx_align_shift(cfg_q);

endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
  import spi_rm_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              half_tick,
  output logic [4:0]        div_cfg_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              irq_o
);

  logic              mode_en, idle_cpol, xfer_load, xfer_busy, xfer_done;
  logic              ne_set, nf_set;
  logic [1:0]        ev_bits, mask_bits;
  xfer_cfg_t         load_cfg;
  logic [DATA_W-1:0] load_word, rx_word;

  spi_rm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (xfer_busy),
    .done      (xfer_done),
    .rx_word   (rx_word),
    .mode_en   (mode_en),
    .idle_cpol (idle_cpol),
    .div_cfg   (div_cfg_o),
    .load      (xfer_load),
    .load_cfg  (load_cfg),
    .load_word (load_word),
    .ne_set    (ne_set),
    .nf_set    (nf_set),
    .ev_bits   (ev_bits),
    .mask_bits (mask_bits),
    .irq       (irq_o)
  );

  spi_rm_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (mode_en),
    .idle_cpol (idle_cpol),
    .load      (xfer_load),
    .load_cfg  (load_cfg),
    .load_word (load_word),
    .half_tick (half_tick),
    .miso_i    (miso_i),
    .busy      (xfer_busy),
    .done      (xfer_done),
    .sck_o     (sck_o),
    .mosi_o    (mosi_o),
    .rx_word   (rx_word)
  );

endmodule

// File: rtl/spi_rm_chk.sv
module spi_rm_chk
  import spi_rm_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              irq_o,
  input logic              mode_en,
  input logic              busy,
  input logic              ne_set,
  input logic [1:0]        ev_bits,
  input logic [1:0]        mask_bits
);

  AST_NE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ne_set |=> ev_bits[1]); // R8

  AST_NF_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ev_bits[0]); // R8

  AST_W1C_NE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_EVENT) && bus_wdata[EV_NE_BIT] && !ne_set)
      |=> !ev_bits[1]); // R9

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_bits == 2'b00) |-> !irq_o); // R10

  AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(mode_en)); // R7

  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> !busy); // R12

endmodule

bind spi_regmaster spi_rm_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_o     (irq_o),
  .mode_en   (mode_en),
  .busy      (xfer_busy),
  .ne_set    (ne_set),
  .ev_bits   (ev_bits),
  .mask_bits (mask_bits)
);

// File: tb/sim_spi_regmaster.sv
module sim_spi_regmaster;

  localparam logic [5:0] A_MODE = 6'h20, A_EV = 6'h24, A_MASK = 6'h28,
                         A_CMD = 6'h2C, A_TX = 6'h30, A_RX = 6'h34;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        half_tick = 1'b0;
  logic [4:0]  div_cfg_o;
  logic        sck_o, mosi_o, irq_o;
  logic        miso_i = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int edges = 0;
  logic [31:0] cap = '0;
  logic bcpol = 1'b0, bcpha = 1'b0, sck_prev = 1'b0;

  always #10 clk = ~clk;

  spi_regmaster u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .half_tick(half_tick),
    .div_cfg_o(div_cfg_o), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i),
    .irq_o(irq_o)
  );

  initial begin
    forever begin
      @(negedge clk);
      half_tick = ~half_tick;
    end
  end

  // edge monitor: counts clock transitions, records data at sampling edges
  always @(negedge clk) begin
    if (sck_o !== sck_prev) begin
      edges = edges + 1;
      if ((sck_o != bcpol) == (bcpha == 1'b0)) cap = {cap[30:0], mosi_o};
    end
    sck_prev = sck_o;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] mk_mode(input logic loop, cpol, cpha, msb, master, en,
                                          input logic [3:0] code, input logic align);
    return ({31'd0, loop} << 30) | ({31'd0, cpol} << 29) | ({31'd0, cpha} << 28) |
           ({31'd0, msb} << 26) | ({31'd0, master} << 25) | ({31'd0, en} << 24) |
           ({28'd0, code} << 20) | ({31'd0, align} << 14);
  endfunction

  function automatic logic [31:0] rev(input logic [31:0] w, input int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = w[n-1-i];
    return r;
  endfunction

  task automatic wait_ne(output logic ok);
    logic [31:0] e;
    ok = 1'b0;
    for (int i = 0; i < 2000 && !ok; i++) begin
      rd(A_EV, e);
      if (e[9]) ok = 1'b1;
    end
  endtask

  // one word: checks transition count, sampled bit sequence, receive word, events
  task automatic run_xfer(input string rq, input logic cpol, cpha, msb,
                          input logic [3:0] code, input logic loop, align,
                          input logic [31:0] txreg, input logic [31:0] word,
                          input logic miso_v, input logic [31:0] exp_rx);
    logic [31:0] d;
    logic ok;
    int n;
    n = (code == 4'd0) ? 32 : int'(code) + 1;
    bcpol = cpol; bcpha = cpha; miso_i = miso_v;
    wr(A_MODE, mk_mode(loop, cpol, cpha, msb, 1'b1, 1'b1, code, align));
    @(negedge clk);
    check("R5 idle level", {31'd0, sck_o}, {31'd0, cpol});
    wr(A_EV, 32'hFFFF_FFFF);
    edges = 0; cap = '0;
    wr(A_TX, txreg);
    wait_ne(ok);
    check("R8 word completes", {31'd0, ok}, 32'd1);
    check("R3 transition count", edges, 2 * n);
    check("R4 bit order", cap & ((n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1)),
          msb ? word : rev(word, n));
    rd(A_RX, d);
    check(rq, d, exp_rx);
    rd(A_EV, d);
    check("R8 both events", d, 32'h0000_0300);
    check("R5 idle after word", {31'd0, sck_o}, {31'd0, cpol});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_MODE, d); check("R1 mode", d, 0);
    rd(A_EV, d);   check("R1 event", d, 0);
    rd(A_MASK, d); check("R1 mask", d, 0);
    rd(A_CMD, d);  check("R1 command", d, 0);
    rd(A_TX, d);   check("R1 transmit", d, 0);
    rd(A_RX, d);   check("R1 receive", d, 0);
    check("R1 pins", {29'd0, sck_o, mosi_o, irq_o}, 0);
  endtask

  task automatic t_mode_rw;
    logic [31:0] d;
    wr(A_MODE, 32'hFFFF_FFFF);
    rd(A_MODE, d); check("R2 mode bits", d, 32'h7FFF_4000);
    check("R2 divider cfg", {27'd0, div_cfg_o}, 32'h1F);
    wr(A_MODE, 32'h0805_0000);
    check("R2 divider cfg", {27'd0, div_cfg_o}, 32'h15);
    wr(A_CMD, 32'h1234_5678);
    rd(A_CMD, d); check("R2 command", d, 32'h1234_5678);
    wr(A_MODE, 0);
  endtask

  task automatic t_w1c_irq;
    logic [31:0] d;
    run_xfer("R6 loop", 1'b0, 1'b0, 1'b1, 4'd7, 1'b1, 1'b0, 32'h3C, 32'h3C, 1'b0, 32'h3C);
    wr(A_MASK, 0);
    check("R10 mask zero", {31'd0, irq_o}, 0);
    wr(A_MASK, 32'h200);
    check("R10 ne masked in", {31'd0, irq_o}, 1);
    wr(A_EV, 32'h200);
    rd(A_EV, d); check("R9 clear ne only", d, 32'h100);
    check("R10 after clear", {31'd0, irq_o}, 0);
    wr(A_MASK, 32'h300);
    check("R10 nf masked in", {31'd0, irq_o}, 1);
    wr(A_EV, 32'h000);
    rd(A_EV, d); check("R9 zero write keeps", d, 32'h100);
    wr(A_EV, 32'hFFFF_FFFF);
    rd(A_EV, d); check("R9 clear all", d, 0);
    check("R10 none pending", {31'd0, irq_o}, 0);
    wr(A_MASK, 0);
  endtask

  task automatic t_dropped;
    logic [31:0] d;
    bcpol = 1'b0; bcpha = 1'b0;
    wr(A_MODE, mk_mode(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd7, 1'b0));
    wr(A_EV, 32'hFFFF_FFFF);
    edges = 0;
    wr(A_TX, 32'h55);
    repeat (100) @(posedge clk);
    wr(A_MODE, mk_mode(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7, 1'b0));
    wr(A_TX, 32'h55);
    repeat (100) @(posedge clk);
    wr(A_MODE, mk_mode(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd7, 1'b0));
    repeat (100) @(posedge clk);
    @(negedge clk);
    check("R7 no transitions", edges, 0);
    rd(A_EV, d); check("R7 no events", d, 0);
  endtask

  task automatic t_abort;
    logic [31:0] d;
    bcpol = 1'b0; bcpha = 1'b0;
    wr(A_MODE, mk_mode(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd0, 1'b0));
    wr(A_EV, 32'hFFFF_FFFF);
    wr(A_TX, 32'hFFFF_0000);
    repeat (30) @(posedge clk);
    wr(A_MODE, mk_mode(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 1'b0));
    check("R12 clock to idle", {31'd0, sck_o}, 1);
    repeat (200) @(posedge clk);
    rd(A_EV, d); check("R12 no receive event", d, 32'h100);
    run_xfer("R12 restart", 1'b0, 1'b0, 1'b1, 4'd0, 1'b1, 1'b0,
             32'h8000_0001, 32'h8000_0001, 1'b0, 32'h8000_0001);
  endtask

  task automatic t_midchange;
    logic [31:0] d;
    logic ok;
    bcpol = 1'b0; bcpha = 1'b0;
    wr(A_MODE, mk_mode(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd15, 1'b0));
    wr(A_EV, 32'hFFFF_FFFF);
    edges = 0; cap = '0;
    wr(A_TX, 32'h8421);
    repeat (20) @(posedge clk);
    wr(A_MODE, mk_mode(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd7, 1'b1));
    wait_ne(ok);
    check("R13 completes", {31'd0, ok}, 1);
    check("R13 length kept", edges, 32);
    check("R13 order kept", cap & 32'hFFFF, 32'h8421);
    rd(A_RX, d); check("R13 layout kept", d, 32'h8421);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    t_reset();
    t_mode_rw();
    run_xfer("R6 loop 8b", 1'b0, 1'b0, 1'b1, 4'd7, 1'b1, 1'b0, 32'hA5, 32'hA5, 1'b0, 32'hA5);
    run_xfer("R6 loop 4b", 1'b1, 1'b1, 1'b0, 4'd3, 1'b1, 1'b0, 32'hB, 32'hB, 1'b0, 32'hB);
    run_xfer("R3 32b", 1'b0, 1'b1, 1'b1, 4'd0, 1'b1, 1'b0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, 32'hDEAD_BEEF);
    run_xfer("R6 pin ones", 1'b1, 1'b0, 1'b0, 4'd15, 1'b0, 1'b0, 32'h1234, 32'h1234, 1'b1, 32'hFFFF);
    run_xfer("R6 pin zeros", 1'b0, 1'b0, 1'b1, 4'd7, 1'b0, 1'b0, 32'hFF, 32'hFF, 1'b0, 32'h0);
    run_xfer("R3 upper bits ignored", 1'b0, 1'b0, 1'b1, 4'd12, 1'b1, 1'b0, 32'hFFFF_1ABC, 32'h1ABC, 1'b0, 32'h1ABC);
    run_xfer("R11 msb 8b", 1'b0, 1'b0, 1'b1, 4'd7, 1'b1, 1'b1, 32'hC300_0000, 32'hC3, 1'b0, 32'h00C3_0000);
    run_xfer("R11 lsb 8b", 1'b0, 1'b1, 1'b0, 4'd7, 1'b1, 1'b1, 32'h5A, 32'h5A, 1'b0, 32'h5A00);
    run_xfer("R11 msb 12b", 1'b1, 1'b1, 1'b1, 4'd11, 1'b1, 1'b1, 32'h0ABC_0000, 32'hABC, 1'b0, 32'h0ABC_0000);
    run_xfer("R11 lsb 16b", 1'b0, 1'b0, 1'b0, 4'd15, 1'b1, 1'b1, 32'hC0DE, 32'hC0DE, 1'b0, 32'hC0DE);
    t_w1c_irq();
    t_dropped();
    t_abort();
    t_midchange();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule